// File: doc/BRIEF.md
# Serial Flash Command Engine

This block drives up to four serial NOR flash devices. They share one serial clock, one output data line and one input data line, and each device has its own active-low chip select. A host programs the block through five 32-bit registers: two control words, a status word, a transmit word and a receive word.

In software mode the host places up to four command, address or data bytes in the transmit word and writes a start command. The engine shifts those bytes out and then clocks in up to four reply bytes, which land in the receive word. Typical uses are an identification read (one opcode byte out, three bytes back) and a sector erase (opcode plus three address bytes).

In hardware mode a single command bit issues either a flash status read or a write-enable to the selected device. The engine tracks, for each device, whether a write has been enabled. It raises a transfer-finished flag and, when the write completes, a write-complete flag. Either flag can drive the interrupt output.

Top module: `sfc_engine`

## Requirements
- R1: After reset every chip select is high, the serial clock is low, the interrupt is low, and the control 1 (offset 0x00), control 2 (0x04) and status (0x08) registers read as zero.
- R2: A software transfer (control 1 bit 28 set, control 2 bit 7 written as one) drives low only the chip select chosen by control 2 bits 13:12 for the whole transfer. It shifts out the transmit-count bytes (control 2 bits 3:0) of the transmit word at 0x0C, low byte first, each byte MSB first. The serial clock idles low, the flash samples on the rising edge, and data changes on the falling edge.
- R3: After the transmit bytes, the engine clocks in the receive-count bytes (control 2 bits 6:4). The first byte received lands in bits 7:0 of the receive word at 0x10, the next in bits 15:8, and so on. The receive word is zeroed when a software transfer starts, so unused upper bytes read as zero.
- R4: A transmit or receive count above four is treated as four.
- R5: Every high phase of the serial clock lasts P system clock cycles, where P is control 1 bits 15:8. A value of zero is treated as one.
- R6: The transfer-finished flag (status bit 8) rises exactly (D+1)·2·P system clock cycles after the chip select returns high. D is control 1 bits 7:4.
- R7: In hardware mode (control 1 bit 28 clear), writing control 2 bit 10 sends opcode 0x05 and reads one byte. That byte appears in status bits 7:0.
- R8: In hardware mode, writing control 2 bit 11 sends only opcode 0x06 and sets status bit 12+bank, the write-mode bit of that device.
- R9: A hardware status read that returns bit 0 (write in progress) clear, to a device whose write-mode bit is set, sets status bit 9 (write complete) and clears that write-mode bit. A read that returns bit 0 set changes neither bit.
- R10: A command that does not fit the current mode sets status bit 10 and starts no transfer. "Does not fit" means bit 7 in hardware mode, or bit 10 or 11 in software mode. A command to a device not enabled in control 1 bits 3:0 sets status bit 11 and starts no transfer.
- R11: A write to the status register clears each of bits 11:8 whose written value is zero and keeps each whose written value is one.
- R12: The interrupt output is high when status bit 8 is set with control 2 bit 8 set, or when status bit 9 is set with control 2 bit 9 set.
- R13: A control 2 write that arrives while a transfer or its deselect time is in progress is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | Register access strobe |
| regWe | input | 1 | Write qualifier for the access |
| regAddr | input | 5 | Byte offset of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational, zero when not selected |
| sclk | output | 1 | Serial clock to all devices |
| csN | output | BANKS | Active-low chip select, one per device |
| mosi | output | 1 | Serial data to the devices |
| miso | input | 1 | Serial data from the selected device |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: four devices and an 8-bit prescaler. This brings every device select, the full four-byte transmit and receive range and the count clamp within reach. It programs prescaler values of zero, two, three and four and deselect values of zero, one and three. These exercise the zero-as-one rule and make both the serial high phase and the deselect gap measurable. A behavioural flash model answers the identification and status opcodes, so write completion can be driven both ways by changing the status byte the model returns.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int MAX_BYTES = 4;
  localparam int IDX_W     = 2;
  localparam int CNT_W     = 3;
  localparam int BANK_W    = 2;
  localparam int DSEL_W    = 4;

  localparam logic [4:0] ADDR_CTL1 = 5'h00;
  localparam logic [4:0] ADDR_CTL2 = 5'h04;
  localparam logic [4:0] ADDR_STAT = 5'h08;
  localparam logic [4:0] ADDR_TX   = 5'h0C;
  localparam logic [4:0] ADDR_RX   = 5'h10;

  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;

  typedef enum logic [1:0] {
    CMD_SW   = 2'd0,
    CMD_RDSR = 2'd1,
    CMD_WREN = 2'd2
  } cmdKind_e;

  // request from the register file to the sequencer
  typedef struct packed {
    logic              go;
    cmdKind_e          kind;
    logic [BANK_W-1:0] bank;
    logic [CNT_W-1:0]  txCnt;
    logic [CNT_W-1:0]  rxCnt;
  } startReq_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic              loadByte;
    logic              loadTx;
    logic [IDX_W-1:0]  loadIdx;
    logic              shiftBit;
    logic              sampleBit;
    logic              storeRx;
    logic [IDX_W-1:0]  storeIdx;
    logic              finish;
    cmdKind_e          kind;
    logic [BANK_W-1:0] bank;
  } engStrobe_t;
endpackage

// File: rtl/sfc_ctrl.sv
module sfc_ctrl
  import sfc_pkg::*;
#(
  parameter int BANKS   = 4,
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  startReq_t          req,
  input  logic [PRESC_W-1:0] presc,
  input  logic [DSEL_W-1:0]  dsel,
  output engStrobe_t         strb,
  output logic               busy,
  output logic               sclk,
  output logic [BANKS-1:0]   csN
);
  localparam int DES_W = DSEL_W + PRESC_W + 2;
  localparam int TOT_W = CNT_W + 1;

  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_LOW, ST_HIGH, ST_DESEL} state_e;

  state_e             state;
  logic [PRESC_W-1:0] halfQ, divCnt;
  logic [2:0]         bitCnt;
  logic [TOT_W-1:0]   byteCnt, totalQ;
  logic [CNT_W-1:0]   nTxQ;
  cmdKind_e           kindQ;
  logic [BANK_W-1:0]  bankQ;
  logic [DES_W-1:0]   desCnt, desLimQ;
  logic               selQ, sclkQ;

  logic [PRESC_W-1:0] effPresc;
  logic [DES_W-1:0]   desLimNext;
  logic [TOT_W-1:0]   nxtByte, reqTotal;
  logic               halfDone, lastBit, moreBytes, curTx, nxtTx;
  logic [IDX_W-1:0]   curIdx, nxtIdx;

  function automatic logic isTxByte(input logic [TOT_W-1:0] n, input logic [CNT_W-1:0] nTx);
    return n < TOT_W'(nTx);
  endfunction

  function automatic logic [IDX_W-1:0] idxOf(input logic [TOT_W-1:0] n, input logic [CNT_W-1:0] nTx);
    logic [TOT_W-1:0] rel;
    rel = isTxByte(n, nTx) ? n : (n - TOT_W'(nTx));
    return rel[IDX_W-1:0];
  endfunction

  always_comb begin
    effPresc   = (presc == '0) ? PRESC_W'(1) : presc;
    desLimNext = (DES_W'(dsel) + DES_W'(1)) * (DES_W'(effPresc) << 1);
    reqTotal   = TOT_W'(req.txCnt) + TOT_W'(req.rxCnt);
    nxtByte    = byteCnt + TOT_W'(1);
    halfDone   = (divCnt == halfQ - PRESC_W'(1));
    lastBit    = (bitCnt == 3'd7);
    moreBytes  = (nxtByte < totalQ);
    curTx      = isTxByte(byteCnt, nTxQ);
    nxtTx      = isTxByte(nxtByte, nTxQ);
    curIdx     = idxOf(byteCnt, nTxQ);
    nxtIdx     = idxOf(nxtByte, nTxQ);
  end

  // strobe generation
  always_comb begin
    strb      = '0;
    strb.kind = kindQ;
    strb.bank = bankQ;
    unique case (state)
      ST_LOAD: begin
        strb.loadByte = 1'b1;
        strb.loadTx   = curTx;
        strb.loadIdx  = curIdx;
      end
      ST_LOW: strb.sampleBit = halfDone;
      ST_HIGH: begin
        if (halfDone) begin
          if (!lastBit) begin
            strb.shiftBit = 1'b1;
          end else begin
            strb.storeRx  = !curTx;
            strb.storeIdx = curIdx;
            if (moreBytes) begin
              strb.loadByte = 1'b1;
              strb.loadTx   = nxtTx;
              strb.loadIdx  = nxtIdx;
            end
          end
        end
      end
      ST_DESEL: strb.finish = (desCnt == desLimQ - DES_W'(1));
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfQ   <= '0;
      divCnt  <= '0;
      bitCnt  <= '0;
      byteCnt <= '0;
      totalQ  <= '0;
      nTxQ    <= '0;
      kindQ   <= CMD_SW;
      bankQ   <= '0;
      desCnt  <= '0;
      desLimQ <= '0;
      selQ    <= 1'b0;
      sclkQ   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req.go) begin
            kindQ   <= req.kind;
            bankQ   <= req.bank;
            nTxQ    <= req.txCnt;
            totalQ  <= reqTotal;
            halfQ   <= effPresc;
            desLimQ <= desLimNext;
            byteCnt <= '0;
            bitCnt  <= '0;
            divCnt  <= '0;
            desCnt  <= '0;
            if (reqTotal == '0) begin
              state <= ST_DESEL;
            end else begin
              state <= ST_LOAD;
              selQ  <= 1'b1;
            end
          end
        end
        ST_LOAD: begin
          state  <= ST_LOW;
          divCnt <= '0;
        end
        ST_LOW: begin
          if (halfDone) begin
            sclkQ  <= 1'b1;
            divCnt <= '0;
            state  <= ST_HIGH;
          end else begin
            divCnt <= divCnt + PRESC_W'(1);
          end
        end
        ST_HIGH: begin
          if (halfDone) begin
            sclkQ  <= 1'b0;
            divCnt <= '0;
            if (!lastBit) begin
              bitCnt <= bitCnt + 3'd1;
              state  <= ST_LOW;
            end else begin
              bitCnt <= '0;
              if (moreBytes) begin
                byteCnt <= nxtByte;
                state   <= ST_LOW;
              end else begin
                selQ   <= 1'b0;
                desCnt <= '0;
                state  <= ST_DESEL;
              end
            end
          end else begin
            divCnt <= divCnt + PRESC_W'(1);
          end
        end
        ST_DESEL: begin
          if (desCnt == desLimQ - DES_W'(1)) state <= ST_IDLE;
          else desCnt <= desCnt + DES_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign sclk = sclkQ;

  for (genvar b = 0; b < BANKS; b++) begin : g_cs
    assign csN[b] = ~(selQ && (bankQ == BANK_W'(b)));
  end

  // R2
  one_cs_chk: assert property (@(posedge clk) disable iff (!rstN) $countones(~csN) <= 1);
  // R5
  sclk_sel_chk: assert property (@(posedge clk) disable iff (!rstN) sclk |-> (csN != '1));
  // R5
  div_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_LOW) || (state == ST_HIGH)) |-> (divCnt < halfQ));
  // R13
  go_idle_chk: assert property (@(posedge clk) disable iff (!rstN) req.go |-> !busy);
endmodule

// File: rtl/sfc_datapath.sv
module sfc_datapath
  import sfc_pkg::*;
#(
  parameter int BANKS   = 4,
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regSel,
  input  logic               regWe,
  input  logic [4:0]         regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  engStrobe_t         strb,
  input  logic               busy,
  input  logic               miso,
  output startReq_t          req,
  output logic [PRESC_W-1:0] presc,
  output logic [DSEL_W-1:0]  dsel,
  output logic               mosi,
  output logic               irq
);
  localparam int PAD_BANKS = 4;

  logic               swModeQ;
  logic [BANKS-1:0]   bankEnQ;
  logic [DSEL_W-1:0]  dselQ;
  logic [PRESC_W-1:0] prescQ;
  logic [3:0]         txLenQ;
  logic [2:0]         rxLenQ;
  logic               tfieQ, wcieQ;
  logic [BANK_W-1:0]  bankSelQ;
  logic [31:0]        txReg, rxReg;
  logic [7:0]         flashStat;
  logic               tff, wcf, erfWr, erfAcc;
  logic [BANKS-1:0]   wmBits;
  logic [7:0]         shReg, inReg;

  logic               wrEn, wrCtl1, wrCtl2, wrStat, wrTx, cmdAccept;
  logic               cmdSw, cmdRd, cmdWe, anyCmd, mismatch, bankOk;
  logic [BANK_W-1:0]  wBank;
  logic [PAD_BANKS-1:0] enPad, wmPad;
  logic [CNT_W-1:0]   swTx, swRx;
  logic [7:0]         outByte;

  always_comb begin
    wrEn      = regSel && regWe;
    wrCtl1    = wrEn && (regAddr == ADDR_CTL1);
    wrCtl2    = wrEn && (regAddr == ADDR_CTL2);
    wrStat    = wrEn && (regAddr == ADDR_STAT);
    wrTx      = wrEn && (regAddr == ADDR_TX);
    cmdAccept = wrCtl2 && !busy;
    cmdSw     = regWdata[7];
    cmdRd     = regWdata[10];
    cmdWe     = regWdata[11];
    wBank     = regWdata[13:12];
    anyCmd    = cmdSw || cmdRd || cmdWe;
    mismatch  = swModeQ ? (cmdRd || cmdWe) : cmdSw;
    enPad     = '0;
    enPad[BANKS-1:0] = bankEnQ;
    wmPad     = '0;
    wmPad[BANKS-1:0] = wmBits;
    bankOk    = enPad[wBank];
    swTx      = (regWdata[3:0] > 4'd4) ? CNT_W'(MAX_BYTES) : regWdata[2:0];
    swRx      = (regWdata[6:4] > 3'd4) ? CNT_W'(MAX_BYTES) : regWdata[6:4];
  end

  always_comb begin
    req.go    = cmdAccept && anyCmd && !mismatch && bankOk;
    req.kind  = swModeQ ? CMD_SW : (cmdRd ? CMD_RDSR : CMD_WREN);
    req.bank  = wBank;
    req.txCnt = swModeQ ? swTx : CNT_W'(1);
    req.rxCnt = swModeQ ? swRx : (cmdRd ? CNT_W'(1) : CNT_W'(0));
  end

  // control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swModeQ  <= 1'b0;
      bankEnQ  <= '0;
      dselQ    <= '0;
      prescQ   <= '0;
      txLenQ   <= '0;
      rxLenQ   <= '0;
      tfieQ    <= 1'b0;
      wcieQ    <= 1'b0;
      bankSelQ <= '0;
      txReg    <= '0;
    end else begin
      if (wrCtl1) begin
        swModeQ <= regWdata[28];
        bankEnQ <= regWdata[BANKS-1:0];
        dselQ   <= regWdata[7:4];
        prescQ  <= regWdata[8 +: PRESC_W];
      end
      if (cmdAccept) begin
        txLenQ   <= regWdata[3:0];
        rxLenQ   <= regWdata[6:4];
        tfieQ    <= regWdata[8];
        wcieQ    <= regWdata[9];
        bankSelQ <= wBank;
      end
      if (wrTx) txReg <= regWdata;
    end
  end

  // status flags and per-bank write-mode bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tff       <= 1'b0;
      wcf       <= 1'b0;
      erfWr     <= 1'b0;
      erfAcc    <= 1'b0;
      flashStat <= '0;
      wmBits    <= '0;
    end else begin
      if (wrStat) begin
        tff    <= tff && regWdata[8];
        wcf    <= wcf && regWdata[9];
        erfWr  <= erfWr && regWdata[10];
        erfAcc <= erfAcc && regWdata[11];
      end
      if (cmdAccept && anyCmd) begin
        if (mismatch) erfWr <= 1'b1;
        else if (!bankOk) erfAcc <= 1'b1;
      end
      if (strb.finish) begin
        tff <= 1'b1;
        if (strb.kind == CMD_RDSR) begin
          flashStat <= inReg;
          if (!inReg[0] && wmBits[strb.bank]) begin
            wcf                 <= 1'b1;
            wmBits[strb.bank]   <= 1'b0;
          end
        end else if (strb.kind == CMD_WREN) begin
          wmBits[strb.bank] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    unique case (strb.kind)
      CMD_RDSR: outByte = OP_RDSR;
      CMD_WREN: outByte = OP_WREN;
      default:  outByte = txReg[8*strb.loadIdx +: 8];
    endcase
  end

  // shifters and receive word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      inReg <= '0;
      rxReg <= '0;
    end else begin
      if (strb.loadByte) shReg <= strb.loadTx ? outByte : 8'h00;
      else if (strb.shiftBit) shReg <= {shReg[6:0], 1'b0};
      if (strb.sampleBit) inReg <= {inReg[6:0], miso};
      if (req.go && (req.kind == CMD_SW)) rxReg <= '0;
      else if (strb.storeRx && (strb.kind == CMD_SW)) rxReg[8*strb.storeIdx +: 8] <= inReg;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regSel) begin
      unique case (regAddr)
        ADDR_CTL1: begin
          regRdata[28]              = swModeQ;
          regRdata[8 +: PRESC_W]    = prescQ;
          regRdata[7:4]             = dselQ;
          regRdata[PAD_BANKS-1:0]   = enPad;
        end
        ADDR_CTL2: regRdata = {18'b0, bankSelQ, 2'b00, wcieQ, tfieQ, 1'b0, rxLenQ, txLenQ};
        ADDR_STAT: regRdata = {16'b0, wmPad, erfAcc, erfWr, wcf, tff, flashStat};
        ADDR_TX:   regRdata = txReg;
        ADDR_RX:   regRdata = rxReg;
        default:   regRdata = '0;
      endcase
    end
  end

  assign presc = prescQ;
  assign dsel  = dselQ;
  assign mosi  = shReg[7];
  assign irq   = (tff && tfieQ) || (wcf && wcieQ);

  // R6
  tff_src_chk: assert property (@(posedge clk) disable iff (!rstN) $rose(tff) |-> $past(strb.finish));
  // R8
  wm_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((wmBits & ~$past(wmBits)) != '0) |-> $past(strb.finish && (strb.kind == CMD_WREN)));
  // R10
  forbid_nogo_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(erfWr) || $rose(erfAcc)) |-> $past(!req.go));
endmodule

// File: rtl/sfc_engine.sv
module sfc_engine
  import sfc_pkg::*;
#(
  parameter int BANKS   = 4,
  parameter int PRESC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             regWe,
  input  logic [4:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  output logic             sclk,
  output logic [BANKS-1:0] csN,
  output logic             mosi,
  input  logic             miso,
  output logic             irq
);
  startReq_t          req;
  engStrobe_t         strb;
  logic               busy;
  logic [PRESC_W-1:0] presc;
  logic [DSEL_W-1:0]  dsel;

  sfc_datapath #(.BANKS(BANKS), .PRESC_W(PRESC_W)) u_dp (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strb(strb), .busy(busy),
    .miso(miso), .req(req), .presc(presc), .dsel(dsel), .mosi(mosi), .irq(irq)
  );

  sfc_ctrl #(.BANKS(BANKS), .PRESC_W(PRESC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .presc(presc), .dsel(dsel),
    .strb(strb), .busy(busy), .sclk(sclk), .csN(csN)
  );
endmodule

// File: tb/sim_sfc_engine.sv
module sim_sfc_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CTL1 = 5'h00, A_CTL2 = 5'h04, A_STAT = 5'h08, A_TX = 5'h0C, A_RX = 5'h10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 1'b0, regWe = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        sclk, mosi, irq;
  logic [3:0]  csN;
  logic        misoR = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfc_engine u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sclk(sclk), .csN(csN),
    .mosi(mosi), .miso(misoR), .irq(irq)
  );

  // ---------------- flash model ----------------
  wire        csIdle = &csN;
  int         bitN = 0, nB = 0, txnCount = 0, lastBank = -1;
  logic [7:0] inSh = '0;
  logic [7:0] logB [0:7];
  logic [7:0] flashStatV = 8'h00;
  time        tRise = 0, tCsUp = 0, tIrq = 0;
  int         lastHigh = 0;

  function automatic logic [7:0] respByte(input int k);
    if (logB[0] == 8'h9F) begin
      case (k)
        0: return 8'hC2;
        1: return 8'h20;
        2: return 8'h17;
        default: return 8'h00;
      endcase
    end else if (logB[0] == 8'h05) return flashStatV;
    return 8'h00;
  endfunction

  always @(negedge csIdle) begin
    txnCount++;
    bitN = 0;
    nB = 0;
    misoR = 1'b0;
    for (int b = 0; b < 4; b++) if (!csN[b]) lastBank = b;
  end

  always @(posedge sclk) begin
    logic [7:0] nb;
    tRise = $time;
    nb = {inSh[6:0], mosi};
    inSh = nb;
    bitN++;
    if (bitN % 8 == 0) begin
      if (nB < 8) logB[nB] = nb;
      nB++;
    end
  end

  always @(negedge sclk) begin
    logic [7:0] rb;
    lastHigh = int'(($time - tRise) / CLK_PERIOD);
    if (nB >= 1) begin
      rb = respByte(nB - 1);
      misoR = rb[7 - (bitN % 8)];
    end else misoR = 1'b0;
  end

  always @(posedge csIdle) tCsUp = $time;
  always @(posedge irq) tIrq = $time;

  // ---------------- helpers ----------------
  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regSel = 1'b1; regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regSel = 1'b0; regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regSel = 1'b1; regWe = 1'b0; regAddr = a;
    #1 d = regRdata;
    regSel = 1'b0;
  endtask

  task automatic waitTff(input string tag);
    logic [31:0] d;
    bit seen = 0;
    for (int i = 0; i < 20000; i++) begin
      rdReg(A_STAT, d);
      if (d[8]) begin seen = 1; break; end
    end
    checkEq({tag, " transfer finished"}, {31'b0, seen}, 32'd1);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic tReset();
    logic [31:0] d;
    checkEq("R1 csN", {28'b0, csN}, 32'hF);
    checkEq("R1 sclk", {31'b0, sclk}, 32'd0);
    checkEq("R1 irq", {31'b0, irq}, 32'd0);
    rdReg(A_CTL1, d); checkEq("R1 ctl1", d, 32'd0);
    rdReg(A_CTL2, d); checkEq("R1 ctl2", d, 32'd0);
    rdReg(A_STAT, d); checkEq("R1 status", d, 32'd0);
  endtask

  task automatic tIdRead();
    logic [31:0] d;
    int n0 = txnCount;
    wrReg(A_CTL1, 32'h1000_021F);
    wrReg(A_TX, 32'h0000_009F);
    wrReg(A_STAT, 32'd0);
    wrReg(A_CTL2, 32'h0000_20B1);
    waitTff("R2 id");
    checkEq("R2 one transaction", txnCount - n0, 32'd1);
    checkEq("R2 bank 2 selected", lastBank, 32'd2);
    checkEq("R2 opcode", {24'b0, logB[0]}, 32'h9F);
    checkEq("R3 byte count", nB, 32'd4);
    rdReg(A_RX, d); checkEq("R3 id word", d, 32'h0017_20C2);
    checkEq("R5 high phase P=2", lastHigh, 32'd2);
  endtask

  task automatic tErase();
    logic [31:0] d;
    wrReg(A_TX, 32'h5634_12D8);
    wrReg(A_STAT, 32'd0);
    wrReg(A_CTL2, 32'h0000_0087);
    waitTff("R4 erase");
    checkEq("R4 clamp to four bytes", nB, 32'd4);
    checkEq("R2 bank 0 selected", lastBank, 32'd0);
    checkEq("R2 bytes low first", {logB[0], logB[1], logB[2], logB[3]}, 32'hD812_3456);
    rdReg(A_RX, d); checkEq("R3 rx cleared", d, 32'd0);
  endtask

  task automatic tTiming();
    logic [31:0] d;
    wrReg(A_CTL1, 32'h1000_003F);
    wrReg(A_TX, 32'h0000_00A5);
    wrReg(A_STAT, 32'd0);
    wrReg(A_CTL2, 32'h0000_1181);
    waitTff("R6 t1");
    checkEq("R2 byte A5", {24'b0, logB[0]}, 32'hA5);
    checkEq("R5 zero prescale as one", lastHigh, 32'd1);
    checkEq("R6 deselect D=3 P=1", int'((tIrq - tCsUp) / CLK_PERIOD), 32'd8);
    checkEq("R12 irq on finish", {31'b0, irq}, 32'd1);
    wrReg(A_STAT, 32'd0);
    checkEq("R12 irq after clear", {31'b0, irq}, 32'd0);
    wrReg(A_CTL1, 32'h1000_030F);
    wrReg(A_CTL2, 32'h0000_1181);
    waitTff("R6 t2");
    checkEq("R5 high phase P=3", lastHigh, 32'd3);
    checkEq("R6 deselect D=0 P=3", int'((tIrq - tCsUp) / CLK_PERIOD), 32'd6);
    rdReg(A_STAT, d);
    wrReg(A_STAT, 32'd0);
  endtask

  task automatic tWren();
    logic [31:0] d;
    wrReg(A_CTL1, 32'h0000_021F);
    wrReg(A_STAT, 32'd0);
    wrReg(A_CTL2, 32'h0000_3800);
    waitTff("R8 wren");
    checkEq("R8 opcode 06", {24'b0, logB[0]}, 32'h06);
    checkEq("R8 single byte", nB, 32'd1);
    checkEq("R8 bank 3", lastBank, 32'd3);
    rdReg(A_STAT, d); checkEq("R8 write-mode bit 15", {31'b0, d[15]}, 32'd1);
  endtask

  task automatic tRdsr();
    logic [31:0] d;
    flashStatV = 8'h03;
    wrReg(A_STAT, 32'd0);
    wrReg(A_CTL2, 32'h0000_3400);
    waitTff("R7 rdsr busy");
    checkEq("R7 opcode 05", {24'b0, logB[0]}, 32'h05);
    checkEq("R7 two bytes", nB, 32'd2);
    rdReg(A_STAT, d);
    checkEq("R7 flash status byte", {24'b0, d[7:0]}, 32'h03);
    checkEq("R9 no complete while busy", {30'b0, d[15], d[9]}, 32'h2);
    flashStatV = 8'h00;
    wrReg(A_STAT, 32'd0);
    wrReg(A_CTL2, 32'h0000_3600);
    waitTff("R9 rdsr idle");
    rdReg(A_STAT, d);
    checkEq("R9 complete set, wm cleared", {24'b0, d[15:8]}, 32'h03);
    checkEq("R12 irq on write complete", {31'b0, irq}, 32'd1);
    wrReg(A_STAT, 32'h0000_0200);
    rdReg(A_STAT, d);
    checkEq("R11 selective clear", {30'b0, d[9], d[8]}, 32'h2);
    checkEq("R12 irq held by complete", {31'b0, irq}, 32'd1);
    wrReg(A_STAT, 32'd0);
    rdReg(A_STAT, d);
    checkEq("R11 full clear", d, 32'd0);
    checkEq("R12 irq low", {31'b0, irq}, 32'd0);
  endtask

  task automatic tForbid();
    logic [31:0] d;
    int n0 = txnCount;
    wrReg(A_CTL2, 32'h0000_0080);
    repeat (20) @(negedge clk);
    rdReg(A_STAT, d);
    checkEq("R10 send in hw mode", {28'b0, d[11:8]}, 32'h4);
    wrReg(A_CTL1, 32'h1000_0201);
    wrReg(A_STAT, 32'd0);
    wrReg(A_CTL2, 32'h0000_2081);
    repeat (20) @(negedge clk);
    rdReg(A_STAT, d);
    checkEq("R10 disabled bank", {28'b0, d[11:8]}, 32'h8);
    wrReg(A_STAT, 32'd0);
    wrReg(A_CTL2, 32'h0000_0800);
    repeat (20) @(negedge clk);
    rdReg(A_STAT, d);
    checkEq("R10 wren in sw mode", {28'b0, d[11:8]}, 32'h4);
    checkEq("R10 no transaction", txnCount - n0, 32'd0);
    wrReg(A_STAT, 32'd0);
  endtask

  task automatic tBusy();
    logic [31:0] d;
    int n0;
    wrReg(A_CTL1, 32'h1000_040F);
    wrReg(A_TX, 32'h1122_3344);
    wrReg(A_STAT, 32'd0);
    n0 = txnCount;
    wrReg(A_CTL2, 32'h0000_1084);
    repeat (10) @(negedge clk);
    wrReg(A_CTL2, 32'h0000_2081);
    waitTff("R13 busy");
    repeat (50) @(negedge clk);
    checkEq("R13 one transaction", txnCount - n0, 32'd1);
    checkEq("R13 bank kept", lastBank, 32'd1);
    checkEq("R2 four bytes out", {logB[0], logB[1], logB[2], logB[3]}, 32'h4433_2211);
    rdReg(A_CTL2, d); checkEq("R13 ctl2 unchanged", d, 32'h0000_1004);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tReset();
    tIdRead();
    tErase();
    tTiming();
    tWren();
    tRdsr();
    tForbid();
    tBusy();
    summary();
  end
endmodule